// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder

This block sits on the transmit side of a 100 Mbit/s twisted-pair physical layer. It takes one 4-bit nibble from the MAC-side interface per code-group period and turns it into a 5-bit code group. It then shifts that code group out one bit at a time. The extra code space carries control symbols next to the data symbols. The block uses it to mark where a frame starts and ends, to fill the line between frames, and to flag a transmit error inside a frame.

Everything runs in one clock domain, paced by `bitEn`, a one-cycle bit-clock enable. A code group lasts five bit enables. On the first bit enable of each group, the block samples the nibble, enable and error inputs and raises `nibbleTick` for that cycle. The MAC-side logic uses `nibbleTick` as its nibble clock.

When a frame starts, the first two nibbles of the preamble are not encoded. They are replaced by the two-symbol start delimiter. When `txEnable` falls, the block sends the two-symbol end delimiter and then returns to idle.

Top module: `tx_symbol_encoder`

## Requirements
- R1: While `rstN` is low, and after its release until the first group is loaded, `txBit` is 1 (idle line) and `nibbleTick` is 0.
- R2: In a data slot with `txError` low, the nibble is coded as follows (nibble hex → group, most significant bit first): 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: When `txEnable` is high at a group boundary while the line is idle, the group sent is J=11000. The next group is K=10001. The nibble values in these two slots are not encoded. Data slots begin with the third nibble.
- R4: At the first group boundary in a data slot where `txEnable` is low, T=01101 is sent, then R=00111.
- R5: Outside a frame, the idle group 11111 is sent at every group boundary.
- R6: In a data slot with `txEnable` and `txError` both high, the halt group 00100 replaces the data group.
- R7: Each group is shifted out most significant bit first. `txBit` changes only on a cycle where `bitEn` is high, and holds its value otherwise.
- R8: `nibbleTick` is high exactly on every fifth bit enable, starting with the first bit enable after reset. The inputs are sampled on that cycle and set the group sent over the next five bit enables.
- R9: `txError` has no effect outside data slots. In idle slots it still yields 11111, and in the start-delimiter slots it still yields J and K.
- R10: `txEnable` being high during the R slot does not shorten the end delimiter. R is still sent, and a new frame begins with J at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-clock enable; one serial bit per high cycle |
| txNibble | input | 4 | Transmit data nibble |
| txEnable | input | 1 | Frame in progress |
| txError | input | 1 | Replace the current data nibble with the halt symbol |
| txBit | output | 1 | Serial code-group bit stream |
| nibbleTick | output | 1 | Marks the bit enable on which the inputs are sampled |

## Verification
The assertions check, on every cycle, the timing of the serial output:
- `txBit` holds while `bitEn` is low.
- `nibbleTick` lands exactly on every fifth bit enable.
- The line stays at 1 until the first frame is requested.

Only the bench's scenarios can show the symbol content: the full data table, the start and end delimiters, the halt substitution, and the ignored error and enable inputs in control slots. Those depend on the frame sequence being driven.

// File: rtl/tx_symbol_pkg.sv
package tx_symbol_pkg;

  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_HALT = 5'b00100;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_J,
    SEL_K,
    SEL_DATA,
    SEL_HALT,
    SEL_T,
    SEL_R
  } codeSelT;

  typedef struct packed {
    logic    load;
    logic    shift;
    codeSelT sel;
  } strobeT;

  function automatic logic [SYM_W-1:0] dataCode(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] c;
    case (nib)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tx_symbol_ctrl.sv
module tx_symbol_ctrl
  import tx_symbol_pkg::*;
#(
  parameter int GROUP_W = SYM_W
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitEn,
  input  logic   txEnable,
  input  logic   txError,
  output logic   nibbleTick,
  output strobeT strobes
);

  localparam int CNT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(GROUP_W - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND_K,
    ST_DATA,
    ST_SEND_R
  } frameStateT;

  frameStateT state, stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic groupEdge;
  codeSelT selNext;

  assign groupEdge = bitEn && (bitCnt == LAST_BIT);

  // bit position counter: reset to the last position so that the
  // first bit enable after reset loads a fresh group
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= LAST_BIT;
    end else if (bitEn) begin
      if (bitCnt == LAST_BIT) bitCnt <= '0;
      else                    bitCnt <= bitCnt + 1'b1;
    end
  end

  // frame sequencing, evaluated at each group boundary
  always_comb begin
    stateNext = state;
    selNext   = SEL_IDLE;
    case (state)
      ST_IDLE: begin
        if (txEnable) begin
          selNext   = SEL_J;
          stateNext = ST_SEND_K;
        end else begin
          selNext   = SEL_IDLE;
        end
      end
      ST_SEND_K: begin
        selNext   = SEL_K;
        stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (txEnable) begin
          selNext = txError ? SEL_HALT : SEL_DATA;
        end else begin
          selNext   = SEL_T;
          stateNext = ST_SEND_R;
        end
      end
      ST_SEND_R: begin
        selNext   = SEL_R;
        stateNext = ST_IDLE;
      end
      default: begin
        selNext   = SEL_IDLE;
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          state <= ST_IDLE;
    else if (groupEdge) state <= stateNext;
  end

  assign nibbleTick    = groupEdge;
  assign strobes.load  = groupEdge;
  assign strobes.shift = bitEn && !groupEdge;
  assign strobes.sel   = selNext;

endmodule

// File: rtl/tx_symbol_dpath.sv
module tx_symbol_dpath
  import tx_symbol_pkg::*;
#(
  parameter int GROUP_W = SYM_W,
  parameter int DATA_W  = NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] txNibble,
  output logic              txBit
);

  logic [GROUP_W-1:0] shReg;
  logic [GROUP_W-1:0] codeIn;

  always_comb begin
    case (strobes.sel)
      SEL_J:    codeIn = SYM_J;
      SEL_K:    codeIn = SYM_K;
      SEL_DATA: codeIn = dataCode(txNibble);
      SEL_HALT: codeIn = SYM_HALT;
      SEL_T:    codeIn = SYM_T;
      SEL_R:    codeIn = SYM_R;
      default:  codeIn = SYM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= SYM_IDLE;
    end else if (strobes.load) begin
      shReg <= codeIn;
    end else if (strobes.shift) begin
      shReg <= {shReg[GROUP_W-2:0], 1'b0};
    end
  end

  assign txBit = shReg[GROUP_W-1];

endmodule

// File: rtl/tx_symbol_encoder.sv
module tx_symbol_encoder
  import tx_symbol_pkg::*;
#(
  parameter int GROUP_W = SYM_W,
  parameter int DATA_W  = NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [DATA_W-1:0] txNibble,
  input  logic              txEnable,
  input  logic              txError,
  output logic              txBit,
  output logic              nibbleTick
);

  strobeT strobes;

  tx_symbol_ctrl #(.GROUP_W(GROUP_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .txEnable   (txEnable),
    .txError    (txError),
    .nibbleTick (nibbleTick),
    .strobes    (strobes)
  );

  tx_symbol_dpath #(.GROUP_W(GROUP_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txNibble (txNibble),
    .txBit    (txBit)
  );

endmodule

// File: rtl/tx_symbol_checker.sv
module tx_symbol_checker #(
  parameter int GROUP_W = 5
) (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic txEnable,
  input logic txBit,
  input logic nibbleTick
);

  localparam int CNT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(GROUP_W - 1);

  logic [CNT_W-1:0] sinceTick;
  logic frameSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceTick <= LAST_BIT;
      frameSeen <= 1'b0;
    end else begin
      if (bitEn) begin
        if (sinceTick == LAST_BIT) sinceTick <= '0;
        else                       sinceTick <= sinceTick + 1'b1;
      end
      if (nibbleTick && txEnable) frameSeen <= 1'b1;
    end
  end

  // R7: output only moves on a bit enable
  assert_hold_without_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R8: tick only on a bit enable
  assert_tick_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    nibbleTick |-> bitEn);

  // R8: tick on every fifth bit enable
  assert_tick_cadence_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && sinceTick == LAST_BIT) |-> nibbleTick);

  // R8: no tick on the other bit enables
  assert_no_extra_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && sinceTick != LAST_BIT) |-> !nibbleTick);

  // R5: line idles high before any frame is requested
  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    !frameSeen |-> txBit);

endmodule

bind tx_symbol_encoder tx_symbol_checker #(.GROUP_W(GROUP_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .bitEn      (bitEn),
  .txEnable   (txEnable),
  .txBit      (txBit),
  .nibbleTick (nibbleTick)
);

// File: tb/sim_tx_symbol_encoder.sv
`timescale 1ns/1ps
module sim_tx_symbol_encoder;

  logic       clk = 1'b0;
  logic       rstN;
  logic       bitEn;
  logic [3:0] txNibble;
  logic       txEnable;
  logic       txError;
  logic       txBit;
  logic       nibbleTick;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  localparam logic [4:0] G_I = 5'b11111;
  localparam logic [4:0] G_J = 5'b11000;
  localparam logic [4:0] G_K = 5'b10001;
  localparam logic [4:0] G_T = 5'b01101;
  localparam logic [4:0] G_R = 5'b00111;
  localparam logic [4:0] G_H = 5'b00100;

  logic [4:0] expTable [16];

  always #5 clk = ~clk;

  tx_symbol_encoder u0 (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .txNibble   (txNibble),
    .txEnable   (txEnable),
    .txError    (txError),
    .txBit      (txBit),
    .nibbleTick (nibbleTick)
  );

  task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one code group: five bit enables, each followed by a hold cycle
  task automatic sendGroup(input logic en, input logic err, input logic [3:0] nib,
                           input logic [4:0] exp, input string req);
    logic [4:0] got;
    bit tickOk = 1'b1;
    bit holdOk = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      txEnable = en; txError = err; txNibble = nib; bitEn = 1'b1;
      #1;
      if (nibbleTick !== (i == 0)) tickOk = 1'b0;
      @(negedge clk);
      bitEn = 1'b0;
      got[4-i] = txBit;
      @(negedge clk);
      if (txBit !== got[4-i]) holdOk = 1'b0;
    end
    check(got === exp, req, got, exp);
    check(tickOk, "R8", {4'b0, tickOk}, 5'b1);
    check(holdOk, "R7", {4'b0, holdOk}, 5'b1);
  endtask

  task automatic testReset();
    rstN = 1'b0; bitEn = 1'b0; txEnable = 1'b0; txError = 1'b0; txNibble = 4'h0;
    repeat (4) @(negedge clk);
    check(txBit === 1'b1, "R1", {4'b0, txBit}, 5'b1);
    check(nibbleTick === 1'b0, "R1", {4'b0, nibbleTick}, 5'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txBit === 1'b1, "R1", {4'b0, txBit}, 5'b1);
  endtask

  task automatic testIdle();
    sendGroup(1'b0, 1'b0, 4'h0, G_I, "R5");
    sendGroup(1'b0, 1'b0, 4'h9, G_I, "R5");
    sendGroup(1'b0, 1'b1, 4'h3, G_I, "R9");
  endtask

  task automatic testBasicFrame();
    sendGroup(1'b1, 1'b0, 4'h5, G_J, "R3");
    sendGroup(1'b1, 1'b0, 4'h5, G_K, "R3");
    sendGroup(1'b1, 1'b0, 4'h5, expTable[5], "R2");
    sendGroup(1'b1, 1'b0, 4'hD, expTable[13], "R2");
    sendGroup(1'b0, 1'b0, 4'h0, G_T, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_R, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_I, "R5");
  endtask

  task automatic testAllNibbles();
    sendGroup(1'b1, 1'b1, 4'hA, G_J, "R9");
    sendGroup(1'b1, 1'b1, 4'h7, G_K, "R9");
    for (int n = 0; n < 16; n++) begin
      sendGroup(1'b1, 1'b0, 4'(n), expTable[n], "R2");
    end
    sendGroup(1'b0, 1'b0, 4'h0, G_T, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_R, "R4");
  endtask

  task automatic testHalt();
    sendGroup(1'b1, 1'b0, 4'h5, G_J, "R3");
    sendGroup(1'b1, 1'b0, 4'h5, G_K, "R3");
    sendGroup(1'b1, 1'b0, 4'h1, expTable[1], "R2");
    sendGroup(1'b1, 1'b1, 4'h2, G_H, "R6");
    sendGroup(1'b1, 1'b0, 4'h3, expTable[3], "R6");
    sendGroup(1'b0, 1'b1, 4'h0, G_T, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_R, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_I, "R5");
  endtask

  task automatic testBackToBack();
    sendGroup(1'b1, 1'b0, 4'h5, G_J, "R3");
    sendGroup(1'b1, 1'b0, 4'h5, G_K, "R3");
    sendGroup(1'b1, 1'b0, 4'hE, expTable[14], "R2");
    sendGroup(1'b0, 1'b0, 4'h0, G_T, "R4");
    sendGroup(1'b1, 1'b0, 4'h6, G_R, "R10");
    sendGroup(1'b1, 1'b0, 4'h6, G_J, "R10");
    sendGroup(1'b1, 1'b0, 4'h6, G_K, "R10");
    sendGroup(1'b1, 1'b0, 4'h6, expTable[6], "R2");
    sendGroup(1'b0, 1'b0, 4'h0, G_T, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_R, "R4");
    sendGroup(1'b0, 1'b0, 4'h0, G_I, "R5");
  endtask

  initial begin
    expTable = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                 5'b01010, 5'b01011, 5'b01110, 5'b01111,
                 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    testReset();
    testIdle();
    testBasicFrame();
    testAllNibbles();
    testHalt();
    testBackToBack();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule